// File: doc/BRIEF.md
# Fusable Slab Multiply-Accumulate Array

This block is a square grid of output-stationary multiply-accumulate cells, cut along its height into a set of row slabs. Each slab has its own activation entry on the left edge and its own weight entry on its top edge, so several small tiles can be computed side by side. A weight selector at the top of every slab except the first can instead feed that slab with the weights leaving the bottom row of the slab above it. This joins the two slabs into one taller array. With every selector set, the grid acts as a single full-height array.

Each slab has a power enable. A slab that is switched off holds all of its registers, drives zero on its result port and forwards zero weights downward. Results leave the array through a drain sequence. Every powered slab pushes its accumulators one row down per cycle and presents its bottom row on its own result port, together with a valid flag. The fusion and power settings are taken only while the array is idle, and a busy flag marks the drain. Accumulators are cleared per slab with a synchronous clear mask before a new tile starts.

Top module: `fusable_slab_array`

## Requirements
- R1: After reset `busy` is 0, `drainValid` is 0, `drainData` is 0, all accumulators and operand registers are 0, every slab is powered and no slab is fused.
- R2: In a powered slab with `run` high, each cell adds the product of its incoming signed 8-bit activation and signed 8-bit weight to its signed 32-bit accumulator (wrapping modulo 2^32). It then passes the activation one column to the right and the weight one row down, each through one register. Row r takes `actIn[r*8 +: 8]` at column 0.
- R3: A slab s whose fusion bit is 0 takes its top-row weights from its own port: column c of slab s reads `wgtIn[(s*N+c)*8 +: 8]`.
- R4: When `fuseCfg` bit s (s ≥ 1) has been loaded as 1, the top row of slab s takes, for each column, the weight register of the bottom row of slab s-1. Bit 0 has no effect.
- R5: A slab whose power bit is 0 changes no register (run, clear and drain have no effect on it), keeps its drain valid low and its data zero, and forwards zero weights to a fused slab below.
- R6: While not draining, a set bit in `clrSlab` zeroes all accumulators of that powered slab at the clock edge, taking priority over accumulation. Operand movement continues.
- R7: `drainStart` with `busy` and `run` low starts a drain. For the next N/K cycles `busy` is high. Each powered slab raises its valid and shows its bottom-row accumulators, with column c at `drainData[(s*N+c)*32 +: 32]`, bottom row first. Every edge during the drain moves each row's accumulators one row down and zeroes the top row, so the slab is empty at the end.
- R8: While `busy` is high, `run` and `drainStart` have no effect.
- R9: `cfgWr` loads `fuseCfg` and `powerCfg` only in a cycle where `busy` and `run` are both low. Otherwise the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Accumulate and move operands this cycle |
| clrSlab | input | K | Per-slab synchronous accumulator clear |
| drainStart | input | 1 | Request a drain of all powered slabs |
| cfgWr | input | 1 | Load fusion and power settings when idle |
| fuseCfg | input | K | Bit s joins slab s under slab s-1 (bit 0 unused) |
| powerCfg | input | K | Bit s powers slab s |
| actIn | input | N*8 | Signed activation per row, row r at bits r*8 |
| wgtIn | input | K*N*8 | Signed weight per slab and column |
| drainData | output | K*N*32 | Bottom-row accumulators per slab during drain, else 0 |
| drainValid | output | K | Per-slab drain data valid |
| busy | output | 1 | Drain in progress |

## Verification
The assertions assume that configuration only moves when both `busy` and `run` are low, and that the power setting therefore stays constant across a whole drain. The check that a slab is empty when its drain ends relies on this. The stimulus issues configuration writes at any time, including during drains and while running, but the design only applies them in idle cycles, so the assumption holds at the cells. A behavioural reference in the bench covers independent, paired, fully joined and partly powered layouts, requests made while busy, and random soak traffic. It is compared with every output on every cycle.

// File: rtl/fa_pkg.sv
package fa_pkg;

  // Strobes from the sequencer to the cell grid
  typedef struct packed {
    logic run;    // accumulate and move operands
    logic shift;  // drain: move accumulators one row down
  } strobe_t;

endpackage

// File: rtl/fa_pe.sv
module fa_pe #(
  parameter int DW = 8,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 en,
  input  logic                 run,
  input  logic                 shift,
  input  logic                 clr,
  input  logic signed [DW-1:0] aIn,
  input  logic signed [DW-1:0] wIn,
  input  logic signed [AW-1:0] accAbove,
  output logic signed [DW-1:0] aOut,
  output logic signed [DW-1:0] wOut,
  output logic signed [AW-1:0] acc
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prodExt;

  assign prod    = aIn * wIn;
  assign prodExt = {{(AW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aOut <= '0;
      wOut <= '0;
      acc  <= '0;
    end else if (en) begin
      if (shift) begin
        acc <= accAbove;
      end else begin
        if (clr)      acc <= '0;
        else if (run) acc <= acc + prodExt;
        if (run) begin
          aOut <= aIn;
          wOut <= wIn;
        end
      end
    end
  end

endmodule

// File: rtl/fa_slab.sv
module fa_slab import fa_pkg::*; #(
  parameter int N  = 8,
  parameter int SH = 2,
  parameter int DW = 8,
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              on,
  input  logic              clr,
  input  logic [SH*DW-1:0]  actIn,
  input  logic [N*DW-1:0]   wTop,
  output logic [N*DW-1:0]   wBot,
  output logic [N*AW-1:0]   rowOut,
  output logic              rowValid
);
  logic signed [DW-1:0] aW   [SH][N+1];
  logic signed [DW-1:0] wW   [SH+1][N];
  logic signed [AW-1:0] accW [SH][N];
  logic [SH*N*AW-1:0]   accAll;
  logic [SH*DW-1:0]     unusedAEdge;

  assign rowValid = on && strobes.shift;

  for (genvar r = 0; r < SH; r++) begin : g_row
    assign aW[r][0] = actIn[r*DW +: DW];
    assign unusedAEdge[r*DW +: DW] = aW[r][N];
    for (genvar c = 0; c < N; c++) begin : g_col
      logic signed [AW-1:0] above;
      if (r == 0) begin : g_top
        assign above = '0;
      end else begin : g_mid
        assign above = accW[r-1][c];
      end
      fa_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk      (clk),
        .rstN     (rstN),
        .en       (on),
        .run      (strobes.run),
        .shift    (strobes.shift),
        .clr      (clr),
        .aIn      (aW[r][c]),
        .wIn      (wW[r][c]),
        .accAbove (above),
        .aOut     (aW[r][c+1]),
        .wOut     (wW[r+1][c]),
        .acc      (accW[r][c])
      );
      assign accAll[(r*N+c)*AW +: AW] = accW[r][c];
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_edge
    assign wW[0][c]              = wTop[c*DW +: DW];
    assign wBot[c*DW +: DW]      = on ? wW[SH][c] : '0;
    assign rowOut[c*AW +: AW]    = rowValid ? accW[SH-1][c] : '0;
  end

  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !on |=> $stable(accAll)); // R5

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (clr && on && !strobes.shift) |=> (accAll == '0)); // R6

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.shift) && !strobes.shift && on) |-> (accAll == '0)); // R7

endmodule

// File: rtl/fa_ctrl.sv
module fa_ctrl import fa_pkg::*; #(
  parameter int K  = 4,
  parameter int SH = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         runIn,
  input  logic         drainStart,
  input  logic         cfgWr,
  input  logic [K-1:0] fuseIn,
  input  logic [K-1:0] powerIn,
  output strobe_t      strobes,
  output logic [K-1:0] fuseQ,
  output logic [K-1:0] onQ,
  output logic         busy
);
  localparam int CW = (SH > 1) ? $clog2(SH) : 1;
  localparam logic [CW-1:0] LAST = CW'(SH - 1);

  logic          draining;
  logic [CW-1:0] cnt;
  logic          idle;

  assign idle          = !draining && !runIn;
  assign busy          = draining;
  assign strobes.run   = runIn && !draining;
  assign strobes.shift = draining;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      draining <= 1'b0;
      cnt      <= '0;
      fuseQ    <= '0;
      onQ      <= '1;
    end else begin
      if (draining) begin
        if (cnt == LAST) draining <= 1'b0;
        else             cnt      <= cnt + 1'b1;
      end else if (drainStart && !runIn) begin
        draining <= 1'b1;
        cnt      <= '0;
      end
      if (cfgWr && idle) begin
        fuseQ <= fuseIn;
        onQ   <= powerIn;
      end
    end
  end

  AST_DRAIN_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(drainStart && !runIn)); // R7

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (busy || runIn) |=> ($stable(fuseQ) && $stable(onQ))); // R9

endmodule

// File: rtl/fa_datapath.sv
module fa_datapath import fa_pkg::*; #(
  parameter int N  = 8,
  parameter int K  = 4,
  parameter int DW = 8,
  parameter int AW = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [K-1:0]       clrSlab,
  input  logic [K-1:0]       fuseQ,
  input  logic [K-1:0]       onQ,
  input  logic [N*DW-1:0]    actIn,
  input  logic [K*N*DW-1:0]  wgtIn,
  output logic [K*N*AW-1:0]  drainData,
  output logic [K-1:0]       drainValid
);
  localparam int SH = N / K;
  localparam int WB = N * DW;

  logic [WB-1:0] wTop [K];
  logic [WB-1:0] wBot [K];
  logic          unusedBits;

  assign unusedBits = fuseQ[0] ^ (^wBot[K-1]);

  for (genvar s = 0; s < K; s++) begin : g_slab
    if (s == 0) begin : g_first
      assign wTop[s] = wgtIn[0 +: WB];
    end else begin : g_next
      assign wTop[s] = fuseQ[s] ? wBot[s-1] : wgtIn[s*WB +: WB];
    end

    fa_slab #(.N(N), .SH(SH), .DW(DW), .AW(AW)) u_slab (
      .clk      (clk),
      .rstN     (rstN),
      .strobes  (strobes),
      .on       (onQ[s]),
      .clr      (clrSlab[s]),
      .actIn    (actIn[s*SH*DW +: SH*DW]),
      .wTop     (wTop[s]),
      .wBot     (wBot[s]),
      .rowOut   (drainData[s*N*AW +: N*AW]),
      .rowValid (drainValid[s])
    );
  end

endmodule

// File: rtl/fusable_slab_array.sv
module fusable_slab_array import fa_pkg::*; #(
  parameter int N  = 8,
  parameter int K  = 4,
  parameter int DW = 8,
  parameter int AW = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               run,
  input  logic [K-1:0]       clrSlab,
  input  logic               drainStart,
  input  logic               cfgWr,
  input  logic [K-1:0]       fuseCfg,
  input  logic [K-1:0]       powerCfg,
  input  logic [N*DW-1:0]    actIn,
  input  logic [K*N*DW-1:0]  wgtIn,
  output logic [K*N*AW-1:0]  drainData,
  output logic [K-1:0]       drainValid,
  output logic               busy
);
  localparam int SH = N / K;

  strobe_t      strobes;
  logic [K-1:0] fuseQ;
  logic [K-1:0] onQ;

  fa_ctrl #(.K(K), .SH(SH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .runIn      (run),
    .drainStart (drainStart),
    .cfgWr      (cfgWr),
    .fuseIn     (fuseCfg),
    .powerIn    (powerCfg),
    .strobes    (strobes),
    .fuseQ      (fuseQ),
    .onQ        (onQ),
    .busy       (busy)
  );

  fa_datapath #(.N(N), .K(K), .DW(DW), .AW(AW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .clrSlab    (clrSlab),
    .fuseQ      (fuseQ),
    .onQ        (onQ),
    .actIn      (actIn),
    .wgtIn      (wgtIn),
    .drainData  (drainData),
    .drainValid (drainValid)
  );

endmodule

// File: tb/fusable_slab_array_tb_top.sv
`timescale 1ns/1ps
module fusable_slab_array_tb_top;
  localparam int N  = 8;
  localparam int K  = 4;
  localparam int DW = 8;
  localparam int AW = 32;
  localparam int SH = N / K;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              run = 1'b0;
  logic [K-1:0]      clrSlab = '0;
  logic              drainStart = 1'b0;
  logic              cfgWr = 1'b0;
  logic [K-1:0]      fuseCfg = '0;
  logic [K-1:0]      powerCfg = '1;
  logic [N*DW-1:0]   actIn = '0;
  logic [K*N*DW-1:0] wgtIn = '0;
  logic [K*N*AW-1:0] drainData;
  logic [K-1:0]      drainValid;
  logic              busy;

  always #2.5 clk = ~clk;

  fusable_slab_array #(.N(N), .K(K), .DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rstN(rstN), .run(run), .clrSlab(clrSlab),
    .drainStart(drainStart), .cfgWr(cfgWr), .fuseCfg(fuseCfg),
    .powerCfg(powerCfg), .actIn(actIn), .wgtIn(wgtIn),
    .drainData(drainData), .drainValid(drainValid), .busy(busy)
  );

  int nChecks = 0;
  int nFails  = 0;
  string phase = "R1";

  // behavioural reference state
  int mA [N][N];
  int mW [N][N];
  int mAcc [N][N];
  int nA [N][N];
  int nW [N][N];
  int nAcc [N][N];
  bit [K-1:0] mFuse;
  bit [K-1:0] mOn;
  bit mDrain;
  int mCnt;

  task automatic modelReset();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        mA[r][c] = 0; mW[r][c] = 0; mAcc[r][c] = 0;
      end
    mFuse = '0; mOn = '1; mDrain = 1'b0; mCnt = 0;
  endtask

  task automatic modelStep();
    bit runE;
    bit cfgOk;
    runE  = run && !mDrain;
    cfgOk = cfgWr && !mDrain && !run;
    for (int s = 0; s < K; s++)
      for (int rl = 0; rl < SH; rl++)
        for (int c = 0; c < N; c++) begin
          int r;
          int a;
          int w;
          r = s * SH + rl;
          nA[r][c] = mA[r][c]; nW[r][c] = mW[r][c]; nAcc[r][c] = mAcc[r][c];
          if (mOn[s]) begin
            if (mDrain) begin
              nAcc[r][c] = (rl == 0) ? 0 : mAcc[r-1][c];
            end else begin
              a = (c == 0) ? int'($signed(actIn[r*DW +: DW])) : mA[r][c-1];
              if (rl > 0)                  w = mW[r-1][c];
              else if (s > 0 && mFuse[s])  w = mOn[s-1] ? mW[r-1][c] : 0;
              else                         w = int'($signed(wgtIn[(s*N+c)*DW +: DW]));
              if (clrSlab[s])  nAcc[r][c] = 0;
              else if (runE)   nAcc[r][c] = mAcc[r][c] + a * w;
              if (runE) begin nA[r][c] = a; nW[r][c] = w; end
            end
          end
        end
    mA = nA; mW = nW; mAcc = nAcc;
    if (cfgOk) begin mFuse = fuseCfg; mOn = powerCfg; end
    if (mDrain) begin
      if (mCnt == SH - 1) mDrain = 1'b0;
      else mCnt++;
    end else if (drainStart && !run) begin
      mDrain = 1'b1; mCnt = 0;
    end
  endtask

  task automatic compareAll();
    nChecks++;
    if (busy !== mDrain) begin
      nFails++;
      $display("FAIL %s busy act=%0b exp=%0b", phase, busy, mDrain);
    end
    for (int s = 0; s < K; s++) begin
      bit ev;
      ev = mDrain && mOn[s];
      nChecks++;
      if (drainValid[s] !== ev) begin
        nFails++;
        $display("FAIL %s valid slab %0d act=%0b exp=%0b", phase, s, drainValid[s], ev);
      end
      for (int c = 0; c < N; c++) begin
        int ed;
        int ad;
        ed = ev ? mAcc[s*SH+SH-1][c] : 0;
        ad = int'($signed(drainData[(s*N+c)*AW +: AW]));
        nChecks++;
        if (ad !== ed || $isunknown(drainData[(s*N+c)*AW +: AW])) begin
          nFails++;
          $display("FAIL %s data slab %0d col %0d act=%0d exp=%0d", phase, s, c, ad, ed);
        end
      end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic quiet();
    run = 0; clrSlab = '0; drainStart = 0; cfgWr = 0;
  endtask

  task automatic randOperands();
    for (int i = 0; i < N; i++) actIn[i*DW +: DW] = DW'($urandom);
    for (int i = 0; i < K*N; i++) wgtIn[i*DW +: DW] = DW'($urandom);
  endtask

  task automatic setCfg(input bit [K-1:0] f, input bit [K-1:0] p);
    quiet(); cfgWr = 1; fuseCfg = f; powerCfg = p;
    cyc();
    cfgWr = 0;
  endtask

  task automatic drainAll();
    string keep;
    keep = phase;
    phase = {keep, " R7"};
    quiet(); drainStart = 1;
    cyc();
    drainStart = 0;
    for (int i = 0; i < SH + 2; i++) cyc();
    phase = keep;
  endtask

  task automatic tile(input int len);
    quiet(); run = 1; clrSlab = '1; randOperands();
    cyc();
    clrSlab = '0;
    for (int i = 0; i < len; i++) begin randOperands(); cyc(); end
    run = 0;
    cyc();
    drainAll();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: state straight after reset
    phase = "R1";
    compareAll();
    for (int i = 0; i < 3; i++) cyc();
    drainAll();

    phase = "R2 R3";
    setCfg(4'b0000, 4'b1111);
    tile(20);
    tile(5);

    phase = "R4";
    setCfg(4'b1010, 4'b1111);
    tile(20);
    setCfg(4'b1110, 4'b1111);
    tile(24);
    setCfg(4'b1111, 4'b1111);   // bit 0 has no effect
    tile(24);

    phase = "R5 R6";
    setCfg(4'b1110, 4'b0110);
    tile(20);
    setCfg(4'b0000, 4'b1010);
    tile(12);
    setCfg(4'b1110, 4'b1111);   // reveal frozen contents of formerly gated slabs
    drainAll();

    phase = "R6";
    setCfg(4'b0100, 4'b1111);
    quiet(); run = 1;
    for (int i = 0; i < 30; i++) begin
      randOperands();
      clrSlab = (i % 7 == 3) ? K'($urandom) : '0;
      cyc();
    end
    quiet();
    drainAll();

    phase = "R8 R9";
    setCfg(4'b0000, 4'b1111);
    tile(6);
    quiet(); run = 1; randOperands();
    for (int i = 0; i < 8; i++) cyc();
    run = 0; drainStart = 1;
    cyc();
    drainStart = 1; cfgWr = 1; fuseCfg = 4'b1110; powerCfg = 4'b0001;
    run = 1; randOperands();
    cyc();
    cyc();
    quiet();
    cyc();
    cfgWr = 1; run = 1; fuseCfg = 4'b0110; powerCfg = 4'b0011;
    cyc();
    quiet();
    drainAll();

    phase = "R2 R4 R5 R6 R7 R8 R9";
    for (int i = 0; i < 400; i++) begin
      randOperands();
      run        = ($urandom % 2) == 0;
      clrSlab    = (($urandom % 8) == 0) ? K'($urandom) : '0;
      drainStart = ($urandom % 8) == 0;
      cfgWr      = ($urandom % 12) == 0;
      fuseCfg    = K'($urandom);
      powerCfg   = K'($urandom) | K'(1);
      cyc();
    end
    quiet();
    setCfg(4'b0000, 4'b1111);
    drainAll();

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule